// File: doc/BRIEF.md
# Bus Master Read Command Sequencer

This block turns read requests from a local memory-mapped port into read transactions on a bus master port. Each request carries a DWORD address, a word count and an address space (configuration, I/O or memory). The space comes from an address translation lookup. For configuration and I/O space the request goes out as one command of the matching type. For memory space the block picks the command from the transfer length and the programmed cache-line size. A request that crosses a line boundary is split into several commands, one per line piece.

The bus side reports every word it delivers. It also reports how each transaction ended. After a normal end, a latency-timer expiry, a disconnect or a retry, the block issues a follow-on command for whatever is still owed. After a target or master abort, it completes the local read with filler words flagged as errors. It is then ready for the next request. Physical bus timing is handled elsewhere.

Top module: `bus_read_sequencer`

## Requirements
- R1: A request with space code 2'b00 (configuration) issues command 4'hA. A request with space 2'b01 (I/O) issues command 4'h2. In both cases the command carries the full address and word count, unsplit.
- R2: A memory request (space 2'b10) of one word issues command 4'h6 with length 1.
- R3: A memory request of more than one word issues command 4'hE (read line) for its whole length when it stays within one line. Staying within one line means the address bits below the line size plus the length do not exceed the line size. The line size is given in DWORDs as a power of two.
- R4: A memory request that crosses a line boundary is split at each boundary. Each piece is issued as command 4'h6. Each piece starts where the previous one ended and is no longer than the room left in its line.
- R5: After termination code 3 (retry) with no word delivered, the same command is issued again with the same code, address and length.
- R6: After termination code 1 (latency timer) or code 2 (disconnect), a continuation is issued for the words still owed. It starts at the address after the last delivered word. For a non-crossing memory request, it uses 4'h6 if one word is owed and 4'hE otherwise.
- R7: After termination code 4 (target abort) or code 5 (master abort), every owed word is returned as all-ones with the error flag set, with last on the final one. Afterwards the block accepts a new request.
- R8: Each word delivered by the bus is returned with the error flag clear. The last flag is set only on the word that completes the request.
- R9: When a transaction ends with termination code 0 and nothing is owed, the block accepts a new request on the next cycle. While a request is in progress it accepts none.
- R10: After reset the block is ready for a request, with no command and no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Request DWORD address |
| req_len | input | LW | Words requested (at least 1) |
| req_space | input | 2 | 00 configuration, 01 I/O, 10 memory |
| line_size | input | LW | Cache-line size in DWORDs, power of two |
| cmd_valid | output | 1 | Bus command pending |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_code | output | 4 | Bus read command code |
| cmd_addr | output | AW | Command start DWORD address |
| cmd_len | output | LW | Command length in words |
| bus_dvalid | input | 1 | One word delivered by the bus |
| bus_data | input | DW | Delivered word |
| term_valid | input | 1 | Transaction has ended |
| term_code | input | 3 | 0 done, 1 latency timer, 2 disconnect, 3 retry, 4 target abort, 5 master abort |
| rsp_valid | output | 1 | Response word to requester |
| rsp_data | output | DW | Response word |
| rsp_err | output | 1 | Word is filler after an abort |
| rsp_last | output | 1 | Final word of the request |

## Verification
On every cycle the assertions check several invariants. A command never asks for more than is owed. A read-line command never leaves its line. A retry re-presents the same command. An abort with words owed is followed at once by an error-flagged word. No request is taken while one is in progress, and an idle block holds nothing pending. The exact command sequence for each case needs the bench's scenarios to show it. That covers the space codes, single versus line versus split memory reads, split points under two line sizes, continuation addresses after a disconnect or latency expiry, and the filler words after each abort type.

// File: rtl/bus_read_sequencer.sv
module bus_read_sequencer #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [1:0]    req_space,
  input  logic [LW-1:0] line_size,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [3:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  input  logic          bus_dvalid,
  input  logic [DW-1:0] bus_data,
  input  logic          term_valid,
  input  logic [2:0]    term_code,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last
);
  localparam logic [3:0] CMD_CFG = 4'hA, CMD_IO = 4'h2, CMD_MR = 4'h6, CMD_MRL = 4'hE;
  localparam logic [1:0] SP_CFG = 2'b00, SP_IO = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_XFER, S_FILL} state_t;

  state_t        st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [1:0]    space_q;
  logic          cross_q;

  function automatic logic in_line(input logic [LW-1:0] off, input logic [LW-1:0] len,
                                   input logic [LW-1:0] ls);
    return ({1'b0, off} + {1'b0, len}) <= {1'b0, ls};
  endfunction

  logic [LW-1:0] mask, offs, room, rem_after;
  logic          in_xfer, abort;
  assign mask      = line_size - LW'(1);
  assign offs      = addr_q[LW-1:0] & mask;
  assign room      = line_size - offs;
  assign in_xfer   = (st == S_XFER);
  assign rem_after = rem_q - LW'(bus_dvalid);
  assign abort     = term_code[2];

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = (st == S_ISSUE);
  assign cmd_addr  = addr_q;
  assign cmd_len   = (space_q[1] && cross_q && room < rem_q) ? room : rem_q;

  always_comb begin
    if (space_q == SP_CFG)               cmd_code = CMD_CFG;
    else if (space_q == SP_IO)           cmd_code = CMD_IO;
    else if (cross_q || rem_q == LW'(1)) cmd_code = CMD_MR;
    else                                 cmd_code = CMD_MRL;
  end

  assign rsp_valid = (in_xfer && bus_dvalid && rem_q != '0) || (st == S_FILL);
  assign rsp_err   = (st == S_FILL);
  assign rsp_data  = (st == S_FILL) ? '1 : bus_data;
  assign rsp_last  = rsp_valid && (rem_q == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      space_q <= '0;
      cross_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && req_len != '0) begin
          addr_q  <= req_addr;
          rem_q   <= req_len;
          space_q <= req_space;
          cross_q <= req_space[1] && !in_line(req_addr[LW-1:0] & mask, req_len, line_size);
          st      <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) st <= S_XFER;
        S_XFER: begin
          if (bus_dvalid && rem_q != '0) begin
            addr_q <= addr_q + AW'(1);
            rem_q  <= rem_after;
          end
          if (term_valid) begin
            if (rem_after == '0) st <= S_IDLE;
            else                 st <= abort ? S_FILL : S_ISSUE;
          end
        end
        S_FILL: begin
          addr_q <= addr_q + AW'(1);
          rem_q  <= rem_q - LW'(1);
          if (rem_q == LW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0 && cmd_len <= rem_q));

  assert_line_contained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_MRL) |-> in_line(offs, cmd_len, line_size));

  assert_retry_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && term_valid && term_code == 3'd3 && !bus_dvalid && rem_q != '0)
      |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_code)));

  assert_abort_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && term_valid && abort && rem_after != '0) |=> (rsp_valid && rsp_err));

  assert_one_at_a_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len != '0) |=> !req_ready);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !rsp_valid));
endmodule

// File: tb/sim_bus_read_sequencer.sv
module sim_bus_read_sequencer;
  localparam int AW = 32, LW = 8, DW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0, line_size = 8'd8;
  logic [1:0] req_space = '0;
  logic cmd_valid, cmd_ready = 0;
  logic [3:0] cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic bus_dvalid = 0, term_valid = 0;
  logic [DW-1:0] bus_data = '0;
  logic [2:0] term_code = '0;
  logic rsp_valid, rsp_err, rsp_last;
  logic [DW-1:0] rsp_data;

  bus_read_sequencer #(.AW(AW), .LW(LW), .DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, owed = 0;
  logic [DW-1:0] seq = 32'hD000_0000;
  logic [DW+1:0] exp_q[$];
  string cur_tag = "R8";
  bit finished = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    logic [DW+1:0] e;
    if (exp_q.size() == 0) check({cur_tag, " unexpected rsp"}, 64'(rsp_data), 64'hx);
    else begin
      e = exp_q.pop_front();
      check({cur_tag, " rsp word"}, {30'd0, rsp_err, rsp_last, rsp_data}, {30'd0, e});
    end
  end

  task automatic do_req(logic [AW-1:0] a, logic [LW-1:0] n, logic [1:0] sp);
    while (!req_ready) begin @(posedge clk); #1; end
    req_addr = a; req_len = n; req_space = sp; req_valid = 1;
    owed = int'(n);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic serve(string tag, logic [3:0] code, logic [AW-1:0] a, logic [LW-1:0] n,
                       int ndata, logic [2:0] term);
    cur_tag = tag;
    do @(negedge clk); while (!cmd_valid);
    check({tag, " cmd code"}, 64'(cmd_code), 64'(code));
    check({tag, " cmd addr"}, 64'(cmd_addr), 64'(a));
    check({tag, " cmd len"},  64'(cmd_len),  64'(n));
    cmd_ready = 1;
    @(posedge clk); #1 cmd_ready = 0;
    for (int i = 0; i < ndata; i++) begin
      seq = seq + 1;
      exp_q.push_back({1'b0, owed == 1, seq});
      owed--;
      bus_dvalid = 1; bus_data = seq;
      @(posedge clk); #1;
    end
    bus_dvalid = 0;
    if (term[2]) while (owed > 0) begin
      exp_q.push_back({1'b1, owed == 1, {DW{1'b1}}});
      owed--;
    end
    term_valid = 1; term_code = term;
    @(posedge clk); #1 term_valid = 0;
  endtask

  task automatic idle_check(string tag);
    wait (exp_q.size() == 0);
    @(negedge clk);
    check({tag, " ready after completion"}, 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R10 reset ready", 64'(req_ready), 64'd1);
    check("R10 reset cmd", 64'(cmd_valid), 64'd0);
    check("R10 reset rsp", 64'(rsp_valid), 64'd0);
    @(posedge clk); #1 rst_n = 1;

    do_req(32'h10, 8'd1, 2'b00); serve("R1", 4'hA, 32'h10, 8'd1, 1, 3'd0); idle_check("R9");
    do_req(32'h20, 8'd3, 2'b01); serve("R1", 4'h2, 32'h20, 8'd3, 3, 3'd0); idle_check("R9");
    do_req(32'h100, 8'd1, 2'b10); serve("R2", 4'h6, 32'h100, 8'd1, 1, 3'd0); idle_check("R9");
    do_req(32'h102, 8'd4, 2'b10); serve("R3", 4'hE, 32'h102, 8'd4, 4, 3'd0); idle_check("R9");

    do_req(32'h106, 8'd12, 2'b10);
    serve("R4", 4'h6, 32'h106, 8'd2, 2, 3'd0);
    serve("R4", 4'h6, 32'h108, 8'd8, 8, 3'd0);
    serve("R4", 4'h6, 32'h110, 8'd2, 2, 3'd0);
    idle_check("R4");

    do_req(32'h200, 8'd3, 2'b10);
    serve("R5", 4'hE, 32'h200, 8'd3, 0, 3'd3);
    serve("R5", 4'hE, 32'h200, 8'd3, 3, 3'd0);
    idle_check("R5");

    do_req(32'h300, 8'd5, 2'b10);
    serve("R6", 4'hE, 32'h300, 8'd5, 2, 3'd2);
    serve("R6", 4'hE, 32'h302, 8'd3, 3, 3'd0);
    idle_check("R6");
    do_req(32'h400, 8'd4, 2'b10);
    serve("R6", 4'hE, 32'h400, 8'd4, 3, 3'd1);
    serve("R6", 4'h6, 32'h403, 8'd1, 1, 3'd0);
    idle_check("R6");

    do_req(32'h500, 8'd4, 2'b10);
    serve("R7", 4'hE, 32'h500, 8'd4, 1, 3'd4);
    idle_check("R7");
    do_req(32'h600, 8'd2, 2'b01);
    serve("R7", 4'h2, 32'h600, 8'd2, 0, 3'd5);
    idle_check("R7");

    line_size = 8'd4;
    do_req(32'h3, 8'd2, 2'b10);
    serve("R4", 4'h6, 32'h3, 8'd1, 1, 3'd0);
    serve("R4", 4'h6, 32'h4, 8'd1, 1, 3'd0);
    idle_check("R4");

    check("R8 no leftover rsp", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule